// File: doc/BRIEF.md
# DRAM bus cycle sequencer

This block sits between a simple processor-side request bus and an asynchronous DRAM. It turns each single read or write request into a fixed sequence of named clock phases. Those phases drive the row strobe (`ras_n`), the column strobe (`cas_n`) and the write strobe (`we_n`), and they multiplex the row and column halves of the word address onto a shared address bus `ma`. Static configuration inputs choose one of three column-strobe styles: a two-clock strobe, a one-clock strobe, and a one-clock strobe with address look-ahead. Wait phases can be added. Fast page mode keeps the row open after an access, so that a later access to the same page runs only the column phases. A refresh request is taken only between accesses, and it always closes an open page first.

The phases are `ST_Q1` and `ST_Q1W` (row address on the bus, row strobe high), `ST_Q2` (row strobe falls), `ST_Q3` (column address on the bus, write strobe set up), and then the column-strobe phases. In the two-clock style these are `ST_Q4`, an optional `ST_Q4W`, and `ST_Q5`. In the one-clock styles there is a single `ST_Q4S`. The other states are `ST_IDLE` (no row open), `ST_OPEN` (row held open, waiting), `ST_PRE` (one precharge clock before reopening a new row), `ST_PRE_R` (precharge ahead of a refresh) and `ST_RACK` (refresh accepted).

The transitions are as follows. `ST_IDLE` goes to `ST_RACK` on a refresh request, or to `ST_Q1` on a request. `ST_OPEN` goes to `ST_PRE_R` on a refresh request, to `ST_Q4` or `ST_Q4S` on a page hit, or to `ST_PRE` on a page miss. `ST_Q1` goes to `ST_Q1W` when the first wait is set, and otherwise to `ST_Q2`. From there the path runs `ST_Q2` to `ST_Q3`, then to `ST_Q4` or `ST_Q4S`. `ST_Q4` goes to `ST_Q4W` when the second wait is set, and otherwise to `ST_Q5`. `ST_Q5` goes to `ST_OPEN` when page mode is in effect, and otherwise to `ST_IDLE`. `ST_Q4S` always goes to `ST_OPEN`. `ST_PRE` goes to `ST_Q1`, `ST_PRE_R` goes to `ST_RACK`, and `ST_RACK` goes to `ST_IDLE`.

Top module: `dram_seq`

## Requirements
- R1: While reset is held and just after it, `ras_n`, `cas_n` and `we_n` are high, and `ready`, `rfsh_ack` and `dq_oe` are low.
- R2: With `cfg_one_clk`=0, the column-strobe style is two-clock: `cas_n` is low for 2 clocks per access, plus 1 when `cfg_wait_q4`=1. With `cfg_one_clk`=1, `cas_n` is low for exactly 1 clock per access. `cfg_lookahead` only has an effect when `cfg_one_clk`=1.
- R3: An access started with no row open raises `ready` in clock 5+w1+w4 (two-clock style) or 4+w1 (one-clock styles), counting from the first clock edge that sees the request as clock 1. Here w1 and w4 are `cfg_wait_q1` and `cfg_wait_q4`, and `cfg_wait_q4` is ignored in the one-clock styles.
- R4: For an access that opens a row, `ma` carries the row bits `req_addr[ADDR_W-1:COL_W]` in the first phase. `ras_n` falls in phase 2+w1 of that opening sequence. `cas_n` is only ever low while `ras_n` is low.
- R5: A page hit raises `ready` in clock 2+w4 (two-clock style) or in clock 1 (one-clock styles), with `ras_n` kept low throughout.
- R6: A request hits the open page when all address bits at or above position k match the last access. k is `cfg_page_size` minus `cfg_wide_bus`, clamped to the range 0 to COL_W.
- R7: After an access with page mode in effect, `ras_n` stays low until a page miss or a refresh. Without page mode, `ras_n` is high again before the next request.
- R8: A page miss while a row is open gives exactly one precharge clock with `ras_n` high and then the full opening sequence, so `ready` arrives one clock later than in R3. Every rise of `ras_n` is followed by at least one more clock with `ras_n` high.
- R9: On a write, `dq_out` carries the write data with `dq_oe` high, and `we_n` is low only while `ras_n` is low. On an access that opens a row, `we_n` falls before `cas_n` does. A later read of the same address returns the written data on `rdata`.
- R10: `ready` is high for one clock, during a phase in which `cas_n` is low.
- R11: A refresh request is taken only in `ST_IDLE` or `ST_OPEN`, and it wins over a request in the same clock. `rfsh_ack` pulses for one clock in clock 1 with no row open, or clock 2 with a row open, and `ras_n` and `cas_n` are high while it pulses.
- R12: While a row is open and the block is waiting, `ma` shows the column bits of the live `req_addr` in the look-ahead style. In the other styles it keeps showing the column of the last access.
- R13: In both one-clock styles, page mode is in effect whatever the value of `cfg_page_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_one_clk | input | 1 | 1 selects a one-clock column strobe |
| cfg_lookahead | input | 1 | With cfg_one_clk, selects column look-ahead |
| cfg_page_en | input | 1 | Keep the row open after an access (two-clock style) |
| cfg_wait_q1 | input | 1 | Insert a wait phase after the first phase |
| cfg_wait_q4 | input | 1 | Insert a wait phase inside the two-clock strobe |
| cfg_page_size | input | PG_W | Page size code for hit detection |
| cfg_wide_bus | input | 1 | Wide data bus; shrinks the page span by one bit |
| req | input | 1 | Access request, held until ready |
| req_we | input | 1 | 1 = write |
| req_addr | input | ADDR_W | Word address: row in the upper bits, column in the low COL_W bits |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Read data, valid while ready |
| rfsh_req | input | 1 | Refresh request, held until acknowledged |
| rfsh_ack | output | 1 | Refresh accepted pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| ma | output | MA_W | Multiplexed row/column address |
| dq_out | output | DATA_W | Data driven toward the DRAM |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The bench builds the block with ADDR_W=8, COL_W=4 and DATA_W=16. This gives 16 rows of 16 columns, which a bench-side memory model can cover in full. With these values, random addresses kept to four rows produce frequent page hits, misses and reopens. Page-size codes between 0 and 15 cover both a single-word page and the clamp at the full column range. Random reconfiguration moves the block through all three strobe styles and both wait settings, with page mode on and off.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_Q1,
        ST_Q1W,
        ST_Q2,
        ST_Q3,
        ST_Q4,
        ST_Q4W,
        ST_Q5,
        ST_Q4S,
        ST_OPEN,
        ST_PRE,
        ST_PRE_R,
        ST_RACK
    } seq_state_e;

    typedef enum logic [1:0] {
        MA_ROW,
        MA_COL,
        MA_NEXT
    } ma_sel_e;

    typedef enum logic [1:0] {
        MODE_TWO,
        MODE_ONE,
        MODE_LOOK
    } cas_mode_e;

    function automatic cas_mode_e decode_mode(input logic one_clk, input logic look);
        if (!one_clk)
            return MODE_TWO;
        else if (look)
            return MODE_LOOK;
        else
            return MODE_ONE;
    endfunction

endpackage

// File: rtl/dseq_page_cmp.sv
module dseq_page_cmp #(
    parameter int ADDR_W = 20,
    parameter int COL_W  = 10,
    parameter int PG_W   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] open_addr,
    input  logic [PG_W-1:0]   pg_size,
    input  logic              wide,
    output logic              hit
);

    int lim;
    logic [ADDR_W-1:0] keep;

    // Lowest address bit that must match for a hit.
    always_comb begin
        lim = int'(pg_size) - int'(wide);
        if (lim < 0)
            lim = 0;
        if (lim > COL_W)
            lim = COL_W;
    end

    for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_keep
        assign keep[gi] = (gi >= lim);
    end

    assign hit = (((addr ^ open_addr) & keep) == '0);

endmodule

// File: rtl/dseq_addr_mux.sv
module dseq_addr_mux
    import dseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int COL_W  = 10,
    parameter int MA_W   = 10
) (
    input  ma_sel_e           sel,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [COL_W-1:0]  next_col,
    output logic [MA_W-1:0]   ma
);

    always_comb begin
        unique case (sel)
            MA_ROW:  ma = MA_W'(cur_addr[ADDR_W-1:COL_W]);
            MA_COL:  ma = MA_W'(cur_addr[COL_W-1:0]);
            MA_NEXT: ma = MA_W'(next_col);
            default: ma = '0;
        endcase
    end

endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
    import dseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       hit,
    input  logic       rfsh_req,
    input  cas_mode_e  mode,
    input  logic       page_en,
    input  logic       wait_q1,
    input  logic       wait_q4,
    input  logic       cur_we,
    output seq_state_e state,
    output logic       accept,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       dq_oe,
    output logic       ready,
    output logic       rfsh_ack,
    output ma_sel_e    ma_sel
);

    seq_state_e nxt;
    logic       one_clk;
    logic       page_eff;
    logic       w4_eff;

    assign one_clk  = (mode != MODE_TWO);
    assign page_eff = page_en | one_clk;   // forced in one-clock styles
    assign w4_eff   = wait_q4 & ~one_clk;
    assign accept   = req & ~rfsh_req & ((state == ST_IDLE) | (state == ST_OPEN));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rfsh_req)
                    nxt = ST_RACK;
                else if (req)
                    nxt = ST_Q1;
            end
            ST_OPEN: begin
                if (rfsh_req)
                    nxt = ST_PRE_R;
                else if (req && hit)
                    nxt = one_clk ? ST_Q4S : ST_Q4;
                else if (req)
                    nxt = ST_PRE;
            end
            ST_Q1:    nxt = wait_q1 ? ST_Q1W : ST_Q2;
            ST_Q1W:   nxt = ST_Q2;
            ST_Q2:    nxt = ST_Q3;
            ST_Q3:    nxt = one_clk ? ST_Q4S : ST_Q4;
            ST_Q4:    nxt = w4_eff ? ST_Q4W : ST_Q5;
            ST_Q4W:   nxt = ST_Q5;
            ST_Q5:    nxt = page_eff ? ST_OPEN : ST_IDLE;
            ST_Q4S:   nxt = ST_OPEN;
            ST_PRE:   nxt = ST_Q1;
            ST_PRE_R: nxt = ST_RACK;
            ST_RACK:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        dq_oe    = 1'b0;
        ready    = 1'b0;
        rfsh_ack = 1'b0;
        ma_sel   = MA_ROW;
        unique case (state)
            ST_IDLE, ST_Q1, ST_Q1W, ST_PRE, ST_PRE_R: begin
                ma_sel = MA_ROW;
            end
            ST_RACK: begin
                rfsh_ack = 1'b1;
            end
            ST_Q2: begin
                ras_n = 1'b0;
            end
            ST_Q3: begin
                ras_n  = 1'b0;
                ma_sel = MA_COL;
                we_n   = ~cur_we;
                dq_oe  = cur_we;
            end
            ST_Q4, ST_Q4W: begin
                ras_n  = 1'b0;
                cas_n  = 1'b0;
                ma_sel = MA_COL;
                we_n   = ~cur_we;
                dq_oe  = cur_we;
            end
            ST_Q5, ST_Q4S: begin
                ras_n  = 1'b0;
                cas_n  = 1'b0;
                ma_sel = MA_COL;
                we_n   = ~cur_we;
                dq_oe  = cur_we;
                ready  = 1'b1;
            end
            ST_OPEN: begin
                ras_n  = 1'b0;
                ma_sel = (mode == MODE_LOOK) ? MA_NEXT : MA_COL;
            end
            default: begin
                ras_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int PG_W   = 4,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_one_clk,
    input  logic              cfg_lookahead,
    input  logic              cfg_page_en,
    input  logic              cfg_wait_q1,
    input  logic              cfg_wait_q4,
    input  logic [PG_W-1:0]   cfg_page_size,
    input  logic              cfg_wide_bus,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    input  logic              rfsh_req,
    output logic              rfsh_ack,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [MA_W-1:0]   ma,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    seq_state_e        state;
    cas_mode_e         mode;
    ma_sel_e           ma_sel;
    logic              accept;
    logic              hit;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_we;
    logic [DATA_W-1:0] cur_wd;

    assign mode = decode_mode(cfg_one_clk, cfg_lookahead);

    // Request latch; cur_addr also marks the open page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_we   <= 1'b0;
            cur_wd   <= '0;
        end else if (accept) begin
            cur_addr <= req_addr;
            cur_we   <= req_we;
            cur_wd   <= req_wdata;
        end
    end

    dseq_page_cmp #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .PG_W   (PG_W)
    ) page_cmp_i (
        .addr      (req_addr),
        .open_addr (cur_addr),
        .pg_size   (cfg_page_size),
        .wide      (cfg_wide_bus),
        .hit       (hit)
    );

    dseq_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .hit      (hit),
        .rfsh_req (rfsh_req),
        .mode     (mode),
        .page_en  (cfg_page_en),
        .wait_q1  (cfg_wait_q1),
        .wait_q4  (cfg_wait_q4),
        .cur_we   (cur_we),
        .state    (state),
        .accept   (accept),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .dq_oe    (dq_oe),
        .ready    (ready),
        .rfsh_ack (rfsh_ack),
        .ma_sel   (ma_sel)
    );

    dseq_addr_mux #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .MA_W   (MA_W)
    ) addr_mux_i (
        .sel      (ma_sel),
        .cur_addr (cur_addr),
        .next_col (req_addr[COL_W-1:0]),
        .ma       (ma)
    );

    assign dq_out = cur_wd;
    assign rdata  = dq_in;

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ready,
    input logic rfsh_ack
);

    assert_cas_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    assert_we_in_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ras_n);

    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_ready_in_cas_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !cas_n);

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_ack |=> !rfsh_ack);

    assert_ack_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_ack |-> (ras_n && cas_n));

endmodule

bind dram_seq dseq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ready    (ready),
    .rfsh_ack (rfsh_ack)
);

// File: tb/dram_seq_tb_top.sv
module dram_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int COL_W  = 4;
    localparam int DATA_W = 16;
    localparam int PG_W   = 4;
    localparam int ROW_W  = ADDR_W - COL_W;
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int NWORD  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_one_clk = 1'b0, cfg_lookahead = 1'b0, cfg_page_en = 1'b0;
    logic              cfg_wait_q1 = 1'b0, cfg_wait_q4 = 1'b0, cfg_wide_bus = 1'b0;
    logic [PG_W-1:0]   cfg_page_size = '0;
    logic              req = 1'b0, req_we = 1'b0, rfsh_req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              ready, rfsh_ack, ras_n, cas_n, we_n, dq_oe;
    logic [DATA_W-1:0] rdata, dq_out, dq_in;
    logic [MA_W-1:0]   ma;

    dram_seq #(
        .ADDR_W (ADDR_W), .COL_W (COL_W), .DATA_W (DATA_W), .PG_W (PG_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_one_clk (cfg_one_clk), .cfg_lookahead (cfg_lookahead),
        .cfg_page_en (cfg_page_en), .cfg_wait_q1 (cfg_wait_q1),
        .cfg_wait_q4 (cfg_wait_q4), .cfg_page_size (cfg_page_size),
        .cfg_wide_bus (cfg_wide_bus),
        .req (req), .req_we (req_we), .req_addr (req_addr), .req_wdata (req_wdata),
        .ready (ready), .rdata (rdata), .rfsh_req (rfsh_req), .rfsh_ack (rfsh_ack),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ma (ma),
        .dq_out (dq_out), .dq_oe (dq_oe), .dq_in (dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // DRAM model: row latched at RAS fall, column at CAS fall
    logic [DATA_W-1:0] dmem [NWORD];
    logic [DATA_W-1:0] refm [NWORD];
    logic [ROW_W-1:0]  row_lat = '0;
    logic              prev_ras = 1'b1, prev_cas = 1'b1;

    always @(negedge clk) begin
        if (prev_ras && !ras_n)
            row_lat = ma[ROW_W-1:0];
        if (prev_cas && !cas_n && !we_n)
            dmem[{row_lat, ma[COL_W-1:0]}] = dq_out;
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    assign dq_in = !cas_n ? dmem[{row_lat, ma[COL_W-1:0]}] : '0;

    int n_chk = 0;
    int n_bad = 0;
    bit pg_open = 1'b0;
    logic [ADDR_W-1:0] open_a = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit page_hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] o);
        int k = int'(cfg_page_size) - int'(cfg_wide_bus);
        if (k < 0) k = 0;
        if (k > COL_W) k = COL_W;
        return ((a >> k) == (o >> k));
    endfunction

    function automatic int full_lat();
        if (cfg_one_clk) return 4 + int'(cfg_wait_q1);
        return 5 + int'(cfg_wait_q1) + int'(cfg_wait_q4);
    endfunction

    function automatic int cas_len();
        return cfg_one_clk ? 1 : 2 + int'(cfg_wait_q4);
    endfunction

    task automatic access(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bit hit_e = pg_open && page_hit(a, open_a);
        int exp_lat, cnt = 0, ncas = 0, ras_i = 0, cas_i = 0, we_i = 0;
        bit done = 0;
        string tag;
        if (pg_open) begin
            req_addr = a;
            #1;
            chk(ma == ((cfg_one_clk && cfg_lookahead) ? MA_W'(a[COL_W-1:0]) : MA_W'(open_a[COL_W-1:0])),
                "R12", int'(ma), int'((cfg_one_clk && cfg_lookahead) ? a[COL_W-1:0] : open_a[COL_W-1:0]));
        end
        if (hit_e) begin
            exp_lat = cfg_one_clk ? 1 : 2 + int'(cfg_wait_q4);
            tag = "R5";
        end else if (pg_open) begin
            exp_lat = 1 + full_lat();
            tag = "R8";
        end else begin
            exp_lat = full_lat();
            tag = "R3";
        end
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        while (!done && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1 && !pg_open)
                chk(ma == MA_W'(a[ADDR_W-1:COL_W]), "R4", int'(ma), int'(a[ADDR_W-1:COL_W]));
            if (!cas_n) ncas++;
            if (ras_i == 0 && !ras_n) ras_i = cnt;
            if (cas_i == 0 && !cas_n) cas_i = cnt;
            if (we_i == 0 && !we_n) we_i = cnt;
            if (w && !we_n)
                chk(dq_oe && dq_out == d, "R9", int'(dq_out), int'(d));
            if (ready) done = 1;
        end
        req = 1'b0;
        chk(cnt == exp_lat, tag, cnt, exp_lat);
        chk(ncas == cas_len(), "R2", ncas, cas_len());
        if (!hit_e) begin
            chk(ras_i == (pg_open ? 3 : 2) + int'(cfg_wait_q1), "R4", ras_i,
                (pg_open ? 3 : 2) + int'(cfg_wait_q1));
            if (w) chk(we_i > 0 && we_i < cas_i, "R9", we_i, cas_i - 1);
        end
        if (!w)
            chk(rdata == refm[a], "R9", int'(rdata), int'(refm[a]));
        else
            refm[a] = d;
        pg_open = cfg_page_en || cfg_one_clk;
        open_a  = a;
        @(negedge clk);
        chk(ready == 1'b0, "R10", int'(ready), 0);
        if (cfg_one_clk && !cfg_page_en)
            chk(ras_n == 1'b0, "R13", int'(ras_n), 0);
        else
            chk(ras_n == !pg_open, "R7", int'(ras_n), int'(!pg_open));
    endtask

    task automatic refresh();
        int cnt = 0;
        int exp = pg_open ? 2 : 1;
        rfsh_req = 1'b1;
        while (cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (rfsh_ack) break;
        end
        rfsh_req = 1'b0;
        chk(cnt == exp, "R11", cnt, exp);
        chk(ras_n && cas_n, "R11", int'(ras_n), 1);
        pg_open = 1'b0;
        @(negedge clk);
        chk(rfsh_ack == 1'b0, "R11", int'(rfsh_ack), 0);
    endtask

    task automatic set_cfg(input bit one, input bit look, input bit pen, input bit w1,
                           input bit w4, input logic [PG_W-1:0] ps, input bit wide);
        refresh();
        cfg_one_clk = one; cfg_lookahead = look; cfg_page_en = pen;
        cfg_wait_q1 = w1; cfg_wait_q4 = w4; cfg_page_size = ps; cfg_wide_bus = wide;
        @(negedge clk);
    endtask

    task automatic race_case(input logic [ADDR_W-1:0] a);
        int cnt = 0, exp = pg_open ? 2 : 1;
        req = 1'b1; req_we = 1'b0; req_addr = a; rfsh_req = 1'b1;
        while (cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (rfsh_ack) break;
        end
        rfsh_req = 1'b0;
        chk(cnt == exp && !ready, "R11", cnt, exp);
        cnt = 0;
        while (cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (ready) break;
        end
        req = 1'b0;
        chk(cnt == full_lat() + 1, "R11", cnt, full_lat() + 1);
        chk(rdata == refm[a], "R9", int'(rdata), int'(refm[a]));
        pg_open = cfg_page_en || cfg_one_clk;
        open_a = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0d1a);
        for (int i = 0; i < NWORD; i++) begin
            dmem[i] = '0;
            refm[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n && !ready && !rfsh_ack && !dq_oe, "R1",
            int'({ras_n, cas_n, we_n, ready, rfsh_ack, dq_oe}), 6'b111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && we_n && !ready && !rfsh_ack && !dq_oe, "R1",
            int'({ras_n, cas_n, we_n, ready, rfsh_ack, dq_oe}), 6'b111000);

        // Two-clock style, page mode, widest page (clamp)
        set_cfg(0, 0, 1, 0, 0, 4'd15, 0);
        access(1, 8'h12, 16'hA512);
        access(0, 8'h12, 0);
        access(0, 8'h15, 0);
        access(1, 8'h34, 16'h0C34);
        access(0, 8'h12, 0);
        // Two-clock style without page mode
        set_cfg(0, 1, 0, 0, 0, 4'd4, 0);
        access(1, 8'h20, 16'h2020);
        access(0, 8'h20, 0);
        // Both waits
        set_cfg(0, 0, 1, 1, 1, 4'd4, 0);
        access(1, 8'h51, 16'h5151);
        access(0, 8'h51, 0);
        access(0, 8'h61, 0);
        // One-clock style: wait_q4 ignored, page forced on (R13)
        set_cfg(1, 0, 0, 1, 1, 4'd4, 0);
        access(1, 8'h77, 16'h7777);
        access(0, 8'h77, 0);
        // Look-ahead, one-word page: k = 1 - 1 = 0 (R6)
        set_cfg(1, 1, 1, 0, 0, 4'd1, 1);
        access(1, 8'h40, 16'h4040);
        access(0, 8'h41, 0);
        access(0, 8'h41, 0);
        chk(pg_open && page_hit(8'h41, open_a) && !page_hit(8'h40, open_a), "R6", 1, 1);
        // Refresh and request together with page open
        race_case(8'h40);

        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 20);
            if (r == 0) begin
                set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        1'($urandom), PG_W'($urandom), 1'($urandom));
            end else if (r == 1) begin
                refresh();
            end else if (r == 2) begin
                race_case(ADDR_W'(($urandom % 4) * 16 + ($urandom % 16)));
            end else begin
                access(1'($urandom), ADDR_W'(($urandom % 4) * 16 + ($urandom % 16)),
                       DATA_W'($urandom));
                repeat (int'($urandom % 3)) @(negedge clk);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule